// File: doc/BRIEF.md
# Serial Display Byte Receiver

This block is the display-side receiver of a four-wire serial link. The four wires are an active-low select, a serial clock, a serial data line and a line that marks each byte as an instruction or as display data. All four wires are asynchronous to the system clock. They pass through a two-flop synchroniser, and rising edges of the serial clock are found by comparing consecutive synchronised samples.

While the select line is low, each rising serial clock edge shifts one data bit into the receiver, most significant bit first. When the eighth bit arrives, the receiver samples the instruction/data line at that same edge. It then presents the assembled byte with its kind flag and raises a valid strobe for one system clock. The bit counter wraps, so the next byte can follow with the select still low. Releasing the select throws away any partly received byte.

The control is a three-state machine:
- `RX_IDLE`: the link is deselected.
- `RX_SHIFT`: the receiver is collecting bits.
- `RX_EMIT`: the one-cycle strobe state.

Its transitions are:
- IDLE→SHIFT when the select goes low.
- SHIFT→EMIT on the eighth accepted rising edge.
- EMIT→SHIFT after one cycle with the select still low.
- SHIFT→IDLE and EMIT→IDLE when the select goes high.
- IDLE→IDLE and SHIFT→SHIFT otherwise.

Top module: `disp_serial_rx`

## Requirements
- R1: After reset, `byte_vld` is 0, `byte_q` is 0x00 and `is_data` is 0.
- R2: Data is sampled only on rising serial clock edges. The first bit received lands in `byte_q[7]` and the eighth in `byte_q[0]`.
- R3: The kind line is sampled only at the eighth rising edge. 0 means instruction and 1 means data. Its level during the first seven bits has no effect on `is_data`.
- R4: Each completed byte raises `byte_vld` for exactly one system clock.
- R5: While `csel_n` is high, serial clock and data are ignored: no strobe occurs and `byte_q`/`is_data` keep their values.
- R6: Raising `csel_n` in mid-byte discards the partial byte. The next byte after reselection is assembled from its own eight bits only.
- R7: With `csel_n` held low, consecutive bytes are each delivered in order, each with the kind sampled at its own eighth edge.
- R8: If the select release and the eighth rising edge reach the synchronised domain in the same system cycle, the release wins and no byte is delivered.
- R9: `byte_q` and `is_data` change only in the cycle in which `byte_vld` is high, and hold between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csel_n | input | 1 | Link select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdat | input | 1 | Serial data, asynchronous |
| dsel | input | 1 | Kind line: 0 instruction, 1 data |
| byte_q | output | 8 | Last completed byte |
| is_data | output | 1 | Kind of last completed byte |
| byte_vld | output | 1 | One-cycle strobe per completed byte |

## Verification
The select release and the eighth rising serial edge can fall in the same system cycle, because both wires pass through the same synchroniser. The bench provokes this by driving the final clock rise and the select release at one instant after seven bits. It judges the outcome by the absence of any strobe, by `byte_q` keeping its earlier value, and by a clean byte received right after reselection. Back-to-back bytes also place a completion next to the start of the following byte. Those bytes are judged by their order, their values and each kind flag.

// File: rtl/disp_rx_pkg.sv
package disp_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_EMIT  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/disp_rx_sync.sv
module disp_rx_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[0] <= RST_VAL;
                else        stage[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/disp_rx_edge.sv
module disp_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;

    // A rise needs a low sample first, so two rises are never adjacent (R2)
    assert_rise_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/disp_rx_fsm.sv
module disp_rx_fsm
    import disp_rx_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_hi,
    input  logic            rise,
    input  logic            sd,
    input  logic            ds,
    output logic [BITS-1:0] byte_o,
    output logic            is_data_o,
    output logic            vld_o
);
    localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    rx_state_e       state, nxt;
    logic [CW-1:0]   cnt;
    logic [BITS-2:0] shreg;
    logic            take;
    logic            last_bit;

    assign take     = rise & ~cs_hi;
    assign last_bit = take & (cnt == LAST);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  nxt = cs_hi ? RX_IDLE : RX_SHIFT;
            RX_SHIFT: begin
                if (cs_hi)         nxt = RX_IDLE;
                else if (last_bit) nxt = RX_EMIT;
                else               nxt = RX_SHIFT;
            end
            RX_EMIT:  nxt = cs_hi ? RX_IDLE : RX_SHIFT;
            default:  nxt = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            byte_o    <= '0;
            is_data_o <= 1'b0;
        end else if (cs_hi) begin
            cnt <= '0;
        end else if (take) begin
            shreg <= {shreg[BITS-3:0], sd};
            if (cnt == LAST) begin
                cnt       <= '0;
                byte_o    <= {shreg, sd};
                is_data_o <= ds;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign vld_o = (state == RX_EMIT);

    assert_emit_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);

    assert_release_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (state == RX_IDLE && cnt == '0));

    assert_release_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi && rise) |=> !vld_o);

    assert_counter_wrapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (cnt == '0 && $past(state) == RX_SHIFT));
endmodule

// File: rtl/disp_serial_rx.sv
module disp_serial_rx #(
    parameter int BITS        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csel_n,
    input  logic            sclk,
    input  logic            sdat,
    input  logic            dsel,
    output logic [BITS-1:0] byte_q,
    output logic            is_data,
    output logic            byte_vld
);
    // bit order: {kind, data, clock, select}
    localparam logic [3:0] SYNC_RST = 4'b0001;

    logic [3:0] raw, synced;
    logic       rise;

    assign raw = {dsel, sdat, sclk, csel_n};

    disp_rx_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (synced)
    );

    disp_rx_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (synced[1]),
        .rise (rise)
    );

    disp_rx_fsm #(
        .BITS(BITS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_hi    (synced[0]),
        .rise     (rise),
        .sd       (synced[2]),
        .ds       (synced[3]),
        .byte_o   (byte_q),
        .is_data_o(is_data),
        .vld_o    (byte_vld)
    );

    assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((byte_q != $past(byte_q)) || (is_data != $past(is_data))) |-> byte_vld);

    assert_deselected_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        synced[0] |=> !byte_vld);
endmodule

// File: tb/tb_disp_serial_rx.sv
module tb_disp_serial_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csel_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdat = 1'b0;
    logic       dsel = 1'b0;
    logic [7:0] byte_q;
    logic       is_data;
    logic       byte_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit prev_vld = 1'b0;
    logic [8:0] got [$];

    always #2 clk = ~clk;

    disp_serial_rx dut (
        .clk(clk), .rst_n(rst_n), .csel_n(csel_n), .sclk(sclk),
        .sdat(sdat), .dsel(dsel), .byte_q(byte_q), .is_data(is_data),
        .byte_vld(byte_vld)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // strobe monitor: record bytes, flag strobes wider than one cycle (R4)
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_vld) begin
                got.push_back({is_data, byte_q});
                n_chk++;
                if (prev_vld) begin
                    n_bad++;
                    $display("FAIL R4: actual strobe width 2+ expected 1");
                end
            end
            prev_vld = byte_vld;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input logic ds);
        sclk = 1'b0; sdat = b; dsel = ds;
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(4);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic ds_last, input logic ds_early);
        for (int i = 7; i >= 0; i--)
            send_bit(v[i], (i == 0) ? ds_last : ds_early);
        sclk = 1'b0;
    endtask

    task automatic expect_byte(input string req, input logic [7:0] v, input logic k);
        logic [8:0] e;
        check({req, " count"}, got.size() > 0, 1);
        if (got.size() > 0) begin
            e = got.pop_front();
            check({req, " byte"}, int'(e[7:0]), int'(v));
            check({req, " kind"}, int'(e[8]), int'(k));
        end
    endtask

    task automatic t_reset();   // R1
        check("R1 vld", byte_vld, 0);
        check("R1 byte", byte_q, 0);
        check("R1 kind", is_data, 0);
    endtask

    task automatic t_single();  // R2, R3
        csel_n = 1'b0; wait_clk(4);
        send_byte(8'hA5, 1'b1, 1'b1);
        wait_clk(8);
        expect_byte("R2 single", 8'hA5, 1'b1);
        csel_n = 1'b1; wait_clk(8);
    endtask

    task automatic t_kind_late();  // R3
        csel_n = 1'b0; wait_clk(4);
        send_byte(8'h3C, 1'b0, 1'b1);
        wait_clk(8);
        expect_byte("R3 instr", 8'h3C, 1'b0);
        send_byte(8'hC3, 1'b1, 1'b0);
        wait_clk(8);
        expect_byte("R3 data", 8'hC3, 1'b1);
        csel_n = 1'b1; wait_clk(8);
    endtask

    task automatic t_burst();  // R7, R9
        csel_n = 1'b0; wait_clk(4);
        send_byte(8'h01, 1'b1, 1'b0);
        send_byte(8'h80, 1'b0, 1'b1);
        send_byte(8'hFF, 1'b1, 1'b0);
        wait_clk(8);
        check("R7 burst count", got.size(), 3);
        expect_byte("R7 b0", 8'h01, 1'b1);
        expect_byte("R7 b1", 8'h80, 1'b0);
        expect_byte("R7 b2", 8'hFF, 1'b1);
        sdat = 1'b0; dsel = 1'b0;
        wait_clk(20);
        check("R9 hold byte", byte_q, 8'hFF);
        check("R9 hold kind", is_data, 1);
        csel_n = 1'b1; wait_clk(8);
    endtask

    task automatic t_ignore();  // R5
        csel_n = 1'b1;
        send_byte(8'h00, 1'b0, 1'b0);
        send_byte(8'h00, 1'b0, 1'b0);
        wait_clk(8);
        check("R5 no strobe", got.size(), 0);
        check("R5 byte kept", byte_q, 8'hFF);
        check("R5 kind kept", is_data, 1);
    endtask

    task automatic t_abort();  // R6
        csel_n = 1'b0; wait_clk(4);
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
        sclk = 1'b0; wait_clk(4);
        csel_n = 1'b1; wait_clk(8);
        check("R6 no partial", got.size(), 0);
        csel_n = 1'b0; wait_clk(4);
        send_byte(8'h5A, 1'b0, 1'b1);
        wait_clk(8);
        check("R6 single byte", got.size(), 1);
        expect_byte("R6 fresh", 8'h5A, 1'b0);
        csel_n = 1'b1; wait_clk(8);
    endtask

    task automatic t_collide();  // R8
        csel_n = 1'b0; wait_clk(4);
        for (int i = 0; i < 7; i++) send_bit(1'b0, 1'b0);
        sclk = 1'b0; sdat = 1'b1; wait_clk(4);
        sclk = 1'b1; csel_n = 1'b1;
        wait_clk(10);
        sclk = 1'b0;
        check("R8 dropped", got.size(), 0);
        check("R8 byte kept", byte_q, 8'h5A);
        csel_n = 1'b0; wait_clk(4);
        send_byte(8'h96, 1'b1, 1'b0);
        wait_clk(8);
        expect_byte("R8 recover", 8'h96, 1'b1);
        csel_n = 1'b1; wait_clk(8);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        t_reset();
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_single();
        t_kind_late();
        t_burst();
        t_ignore();
        t_abort();
        t_collide();
        check("R4 leftover", got.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule